// File: doc/BRIEF.md
# SPI Word Buffer with Status, Interrupt and DMA Request Logic

This block is the word-buffering core of a serial peripheral controller. It holds one transmit queue and one receive queue. It sits between a simple register-style access port, used by software or a DMA engine, and the word-level interface of the serial shifter. Software pushes transmit words and pops receive words through data addresses on the access port. The shifter takes transmit words from the head of the transmit queue and pushes received words into the receive queue.

Around the two queues, the block keeps the following:
- programmable interrupt thresholds, which can only be changed while the controller is disabled;
- a five-bit status word;
- sticky error events with a write-one clear register;
- a raw and a masked interrupt vector, and a single interrupt line;
- two DMA request lines, each with its own level and its own enable.

Dropping the enable input empties both queues. Because the threshold registers keep only values below the queue depth, software can find the depth by writing rising values and watching for the first readback that differs.

Top module: `spi_buf_ctrl`

## Requirements
- R1: After reset the following hold:
  - both fill levels are 0;
  - the status word reads 5'b01100 (transmit-empty and receive-empty set);
  - the raw interrupt vector reads 5'b00001;
  - mask, thresholds, DMA levels and DMA enables are 0;
  - the interrupt line is low.
- R2: Each queue is first-in first-out. A write to register index 0 pushes the transmit queue. The shifter takes words with `eng_tx_take` from `eng_tx_data`, and `eng_tx_avail` is high while the transmit queue is non-empty. A read of register index 1 returns the head of the receive queue and pops it. The fill levels read at indexes 4 (transmit) and 5 (receive).
- R3: The status word at index 6 has these bits:
  - bit 0: `eng_busy`;
  - bit 1: transmit queue full;
  - bit 2: transmit queue empty;
  - bit 3: receive queue empty;
  - bit 4: receive queue full.
- R4: The raw vector at index 8 has these bits:
  - bit 0: transmit level at or below the transmit threshold (index 2);
  - bit 1: transmit overflow;
  - bit 2: receive underflow;
  - bit 3: receive overflow;
  - bit 4: receive level strictly above the receive threshold (index 3), so bit 4 sets once threshold+1 words are held.
- R5: The masked vector at index 9 is the raw vector ANDed with the 5-bit mask at index 7. `irq` is the OR of the masked bits.
- R6: A transmit write while the transmit queue is full is dropped and latches raw bit 1. A shifter push while the receive queue is full is dropped and latches raw bit 3.
- R7: A receive read while the receive queue is empty returns 0, leaves the level at 0 and latches raw bit 2.
- R8: Writing the clear register at index 10 clears latched events as follows:
  - bit 0 clears every latched event;
  - bit 1 clears receive underflow;
  - bit 2 clears receive overflow;
  - bit 3 clears transmit overflow.

  A new event in the same cycle wins over the clear.
- R9: While `en` is low, both queues are flushed to level 0, and transmit writes and shifter pushes are ignored.
- R10: The threshold registers (indexes 2 and 3) ignore writes while `en` is high. All four level registers (indexes 2, 3, 12 and 13) ignore values at or above the queue depth.
- R11: DMA requests depend on the DMA enable register at index 11:
  - `tx_dma_req` is high when bit 1 of that register is set and the transmit level is at or below the transmit DMA level (index 12);
  - `rx_dma_req` is high when bit 0 is set and the receive level is above the receive DMA level (index 13).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Controller enable; low flushes both queues |
| eng_busy | input | 1 | Shifter busy flag, reported in status bit 0 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at index 1) |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational from the index |
| eng_tx_avail | output | 1 | Transmit queue holds at least one word |
| eng_tx_data | output | DW | Head of the transmit queue |
| eng_tx_take | input | 1 | Shifter takes the transmit head |
| eng_rx_push | input | 1 | Shifter pushes a received word |
| eng_rx_data | input | DW | Received word |
| irq | output | 1 | OR of the masked interrupt vector |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The bench works on three kinds of boundary.

The first is the threshold boundary. With the receive threshold at 2, the receive interrupt must stay low at two words and rise at the third. A design using at-or-above would fire one word early and break the driver's last-interrupt accounting.

The second is the full and empty edges. A write into a full transmit queue must not alter the level or the order of the words. A read from an empty receive queue must return zero. A design that wrapped its pointers would corrupt the following words.

The third is the per-bit clear. Clearing one event must leave the other events latched. The depth probe must find the first ignored threshold value at exactly the queue depth. A randomized stream of mixed pushes, takes and pops is then checked word by word against queue models in the bench.

// File: rtl/spi_buf_pkg.sv
// Package: shared register indexes and interrupt bit positions of the
// SPI word buffer. Assumes a 4-bit register index.
package spi_buf_pkg;

    typedef enum logic [3:0] {
        A_TXD    = 4'd0,
        A_RXD    = 4'd1,
        A_TXTHR  = 4'd2,
        A_RXTHR  = 4'd3,
        A_TXLVL  = 4'd4,
        A_RXLVL  = 4'd5,
        A_STAT   = 4'd6,
        A_MASK   = 4'd7,
        A_RAW    = 4'd8,
        A_MSKD   = 4'd9,
        A_CLR    = 4'd10,
        A_DMAEN  = 4'd11,
        A_TXDLVL = 4'd12,
        A_RXDLVL = 4'd13
    } reg_idx_e;

    localparam int NIRQ   = 5;
    localparam int NLVREG = 4;

    // Register index of each level register, slot 0..3
    function automatic logic [3:0] lvl_index(input int slot);
        case (slot)
            0:       return A_TXTHR;
            1:       return A_RXTHR;
            2:       return A_TXDLVL;
            default: return A_RXDLVL;
        endcase
    endfunction

endpackage

// File: rtl/spi_buf_fifo.sv
// Module: spi_buf_fifo
// Circular word queue with an occupancy counter. A push when full and a
// pop when empty are ignored. The flush input empties the queue and wins
// over push and pop. Assumes DEPTH >= 2. Pointers wrap explicitly, so any
// depth works.
module spi_buf_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = mem[rp];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write; contents need no reset
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end

endmodule

// File: rtl/spi_buf_lvlreg.sv
// Module: spi_buf_lvlreg
// One level/threshold register. A write is kept only when the value is
// below DEPTH. When LOCK_EN is set, writes are also ignored while the
// enable is high. Assumes the write data is at most 32 bits wide.
module spi_buf_lvlreg #(
    parameter int WW      = 16,
    parameter int DEPTH   = 32,
    parameter bit LOCK_EN = 1'b1,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          we,
    input  logic [WW-1:0] wdata,
    output logic [AW-1:0] value
);

    logic in_range, allowed;

    assign in_range = (32'(wdata) < DEPTH);

    generate
        if (LOCK_EN) begin : g_lock
            assign allowed = !en;
        end else begin : g_free
            assign allowed = 1'b1;
        end
    endgenerate

    // Hold the level; accept in-range writes when allowed
    always_ff @(posedge clk) begin
        if (!rst_n)                         value <= '0;
        else if (we && allowed && in_range) value <= AW'(wdata);
    end

endmodule

// File: rtl/spi_buf_irq.sv
// Module: spi_buf_irq
// Sticky error events, the interrupt mask, and the raw and masked
// vectors. A new event in the same cycle wins over a clear. Bit order of
// the vectors: 0 tx low, 1 tx overflow, 2 rx underflow, 3 rx overflow,
// 4 rx high.
module spi_buf_irq
    import spi_buf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_ovf_ev,
    input  logic            rx_und_ev,
    input  logic            rx_ovf_ev,
    input  logic            tx_low,
    input  logic            rx_high,
    input  logic            clr_we,
    input  logic [3:0]      clr_bits,
    input  logic            mask_we,
    input  logic [NIRQ-1:0] mask_wdata,
    output logic [NIRQ-1:0] mask,
    output logic [NIRQ-1:0] raw,
    output logic [NIRQ-1:0] masked,
    output logic            irq
);

    logic tx_ovf_q, rx_und_q, rx_ovf_q;
    logic clr_txo, clr_rxu, clr_rxo;

    assign clr_txo = clr_we && (clr_bits[0] || clr_bits[3]);
    assign clr_rxu = clr_we && (clr_bits[0] || clr_bits[1]);
    assign clr_rxo = clr_we && (clr_bits[0] || clr_bits[2]);

    // Sticky event latches, set over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_ovf_q <= 1'b0;
            rx_und_q <= 1'b0;
            rx_ovf_q <= 1'b0;
        end else begin
            if (tx_ovf_ev)    tx_ovf_q <= 1'b1;
            else if (clr_txo) tx_ovf_q <= 1'b0;
            if (rx_und_ev)    rx_und_q <= 1'b1;
            else if (clr_rxu) rx_und_q <= 1'b0;
            if (rx_ovf_ev)    rx_ovf_q <= 1'b1;
            else if (clr_rxo) rx_ovf_q <= 1'b0;
        end
    end

    // Interrupt mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= mask_wdata;
    end

    assign raw    = {rx_high, rx_ovf_q, rx_und_q, tx_ovf_q, tx_low};
    assign masked = raw & mask;
    assign irq    = |masked;

endmodule

// File: rtl/spi_buf_ctrl.sv
// Module: spi_buf_ctrl (top)
// Transmit and receive word queues of an SPI controller, with register
// access, status, interrupt and DMA request logic. Assumes DW >= the
// level width and DW >= 5. Register reads are combinational from
// reg_addr. A read at A_RXD pops at the clock edge.
module spi_buf_ctrl
    import spi_buf_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          eng_busy,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [3:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          eng_tx_avail,
    output logic [DW-1:0] eng_tx_data,
    input  logic          eng_tx_take,
    input  logic          eng_rx_push,
    input  logic [DW-1:0] eng_rx_data,
    output logic          irq,
    output logic          tx_dma_req,
    output logic          rx_dma_req
);

    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    logic [LW-1:0]   tx_level, rx_level;
    logic            tx_full, tx_empty, rx_full, rx_empty;
    logic [DW-1:0]   rx_head;
    logic            tx_wr_req, rx_rd_req, rx_push_req;
    logic            tx_ovf_ev, rx_und_ev, rx_ovf_ev;
    logic [AW-1:0]   lvl_val [NLVREG];
    logic [AW-1:0]   tx_thr, rx_thr;
    logic [NIRQ-1:0] mask, raw, masked;
    logic [4:0]      status;
    logic [1:0]      dma_en;

    // Request decode and error events
    assign tx_wr_req   = reg_wr && (reg_addr == A_TXD) && en;
    assign rx_rd_req   = reg_rd && (reg_addr == A_RXD);
    assign rx_push_req = eng_rx_push && en;
    assign tx_ovf_ev   = tx_wr_req && tx_full;
    assign rx_ovf_ev   = rx_push_req && rx_full;
    assign rx_und_ev   = rx_rd_req && rx_empty;

    spi_buf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!en),
        .push  (tx_wr_req),
        .wdata (reg_wdata),
        .pop   (eng_tx_take),
        .rdata (eng_tx_data),
        .level (tx_level),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spi_buf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!en),
        .push  (rx_push_req),
        .wdata (eng_rx_data),
        .pop   (rx_rd_req),
        .rdata (rx_head),
        .level (rx_level),
        .full  (rx_full),
        .empty (rx_empty)
    );

    // Level registers: slots 0/1 are locked thresholds, 2/3 DMA levels
    generate
        for (genvar gi = 0; gi < NLVREG; gi++) begin : g_lvl
            spi_buf_lvlreg #(.WW(DW), .DEPTH(DEPTH), .LOCK_EN(gi < 2)) u_lvl (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (en),
                .we    (reg_wr && (reg_addr == lvl_index(gi))),
                .wdata (reg_wdata),
                .value (lvl_val[gi])
            );
        end
    endgenerate

    assign tx_thr = lvl_val[0];
    assign rx_thr = lvl_val[1];

    spi_buf_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_ovf_ev  (tx_ovf_ev),
        .rx_und_ev  (rx_und_ev),
        .rx_ovf_ev  (rx_ovf_ev),
        .tx_low     (tx_level <= LW'(tx_thr)),
        .rx_high    (rx_level > LW'(rx_thr)),
        .clr_we     (reg_wr && (reg_addr == A_CLR)),
        .clr_bits   (reg_wdata[3:0]),
        .mask_we    (reg_wr && (reg_addr == A_MASK)),
        .mask_wdata (reg_wdata[NIRQ-1:0]),
        .mask       (mask),
        .raw        (raw),
        .masked     (masked),
        .irq        (irq)
    );

    // DMA enable register
    always_ff @(posedge clk) begin
        if (!rst_n)                              dma_en <= 2'b00;
        else if (reg_wr && reg_addr == A_DMAEN)  dma_en <= reg_wdata[1:0];
    end

    assign tx_dma_req   = dma_en[1] && (tx_level <= LW'(lvl_val[2]));
    assign rx_dma_req   = dma_en[0] && (rx_level > LW'(lvl_val[3]));
    assign eng_tx_avail = !tx_empty;
    assign status       = {rx_full, rx_empty, tx_empty, tx_full, eng_busy};

    // Register read multiplexer; empty receive read yields zero
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_RXD:    reg_rdata = rx_empty ? '0 : rx_head;
            A_TXTHR:  reg_rdata = DW'(tx_thr);
            A_RXTHR:  reg_rdata = DW'(rx_thr);
            A_TXLVL:  reg_rdata = DW'(tx_level);
            A_RXLVL:  reg_rdata = DW'(rx_level);
            A_STAT:   reg_rdata = DW'(status);
            A_MASK:   reg_rdata = DW'(mask);
            A_RAW:    reg_rdata = DW'(raw);
            A_MSKD:   reg_rdata = DW'(masked);
            A_DMAEN:  reg_rdata = DW'(dma_en);
            A_TXDLVL: reg_rdata = DW'(lvl_val[2]);
            A_RXDLVL: reg_rdata = DW'(lvl_val[3]);
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_buf_ctrl_chk.sv
// Module: spi_buf_ctrl_chk
// Assertion checker bound into spi_buf_ctrl. It observes ports and
// internal nets of the top.
module spi_buf_ctrl_chk
    import spi_buf_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          reg_wr,
    input logic [3:0]    reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] reg_rdata,
    input logic [LW-1:0] tx_level,
    input logic [LW-1:0] rx_level,
    input logic [AW-1:0] tx_thr,
    input logic [AW-1:0] rx_thr,
    input logic [4:0]    status,
    input logic [4:0]    raw,
    input logic [4:0]    mask,
    input logic          irq,
    input logic          tx_ovf_ev,
    input logic          rx_und_ev,
    input logic          rx_ovf_ev
);

    p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LW'(DEPTH) && rx_level <= LW'(DEPTH));

    p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[1] && status[2]) && !(status[3] && status[4]));

    p_rxrise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw[4]) |-> rx_level == LW'(rx_thr) + LW'(1));

    p_nomask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

    p_txovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovf_ev |=> raw[1]);

    p_und_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_und_ev |-> reg_rdata == '0);

    p_clrall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CLR && reg_wdata[0] &&
         !tx_ovf_ev && !rx_und_ev && !rx_ovf_ev) |=> raw[3:1] == 3'b000);

    p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (tx_level == '0 && rx_level == '0));

    p_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ($stable(tx_thr) && $stable(rx_thr)));

endmodule

bind spi_buf_ctrl spi_buf_ctrl_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tx_level  (tx_level),
    .rx_level  (rx_level),
    .tx_thr    (tx_thr),
    .rx_thr    (rx_thr),
    .status    (status),
    .raw       (raw),
    .mask      (mask),
    .irq       (irq),
    .tx_ovf_ev (tx_ovf_ev),
    .rx_und_ev (rx_und_ev),
    .rx_ovf_ev (rx_ovf_ev)
);

// File: tb/spi_buf_ctrl_tb.sv
// Testbench for spi_buf_ctrl: directed corner cases, then a seeded
// random stream checked against queue models.
module spi_buf_ctrl_tb;
    import spi_buf_pkg::*;

    localparam int DW    = 16;
    localparam int DEPTH = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          eng_busy = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          eng_tx_avail;
    logic [DW-1:0] eng_tx_data;
    logic          eng_tx_take = 1'b0;
    logic          eng_rx_push = 1'b0;
    logic [DW-1:0] eng_rx_data = '0;
    logic          irq, tx_dma_req, rx_dma_req;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    spi_buf_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .eng_busy(eng_busy),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_tx_avail(eng_tx_avail), .eng_tx_data(eng_tx_data),
        .eng_tx_take(eng_tx_take), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .irq(irq),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic take(output logic [DW-1:0] d);
        @(negedge clk);
        d = eng_tx_data; eng_tx_take = 1'b1;
        @(posedge clk); #1;
        eng_tx_take = 1'b0;
    endtask

    task automatic rx_in(input logic [DW-1:0] d);
        @(negedge clk);
        eng_rx_push = 1'b1; eng_rx_data = d;
        @(posedge clk); #1;
        eng_rx_push = 1'b0;
    endtask

    function automatic logic [31:0] status_exp(input int txl, input int rxl, input logic busy);
        return {27'b0, rxl == DEPTH, rxl == 0, txl == 0, txl == DEPTH, busy};
    endfunction

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected done");
        finish_sim();
    end

    initial begin
        logic [DW-1:0] v;
        logic [DW-1:0] tq[$];
        logic [DW-1:0] rq[$];
        int found;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(A_TXLVL, v); chk("R1 tx level", v, 0);
        rd(A_RXLVL, v); chk("R1 rx level", v, 0);
        rd(A_STAT, v);  chk("R1 status", v, 32'h0C);
        rd(A_RAW, v);   chk("R1 raw", v, 32'h01);
        rd(A_MASK, v);  chk("R1 mask", v, 0);
        chk("R1 irq", irq, 0);

        // R3 busy bit
        eng_busy = 1'b1;
        rd(A_STAT, v);  chk("R3 busy status", v, 32'h0D);

        // R10 thresholds and depth probe (disabled)
        wr(A_TXTHR, 4); wr(A_RXTHR, 2);
        rd(A_TXTHR, v); chk("R10 tx thr", v, 4);
        rd(A_RXTHR, v); chk("R10 rx thr", v, 2);
        wr(A_TXTHR, 40);
        rd(A_TXTHR, v); chk("R10 out of range ignored", v, 4);
        found = 0;
        for (int k = 2; k < 40; k++) begin
            wr(A_RXTHR, DW'(k)); rd(A_RXTHR, v);
            if (found == 0 && v != DW'(k)) found = k;
        end
        chk("R10 depth probe", found, DEPTH);
        wr(A_RXTHR, 2);

        // R9 pushes ignored while disabled
        wr(A_TXD, 16'h5555);
        rd(A_TXLVL, v); chk("R9 disabled write ignored", v, 0);

        @(negedge clk); en = 1'b1;
        wr(A_TXTHR, 7);
        rd(A_TXTHR, v); chk("R10 locked while enabled", v, 4);

        // R2 R4 transmit queue and low threshold
        for (int i = 0; i < 5; i++) wr(A_TXD, DW'(16'h1000 + i));
        rd(A_TXLVL, v); chk("R2 tx level 5", v, 5);
        rd(A_RAW, v);   chk("R4 tx above thr", v & 1, 0);
        take(v);        chk("R2 tx head order", v, 16'h1000);
        rd(A_RAW, v);   chk("R4 tx at thr", v & 1, 1);

        // R6 transmit overflow
        for (int i = 0; i < 28; i++) wr(A_TXD, DW'(16'h2000 + i));
        rd(A_STAT, v);  chk("R3 tx full status", v, status_exp(32, 0, 1));
        wr(A_TXD, 16'hDEAD);
        rd(A_TXLVL, v); chk("R6 tx level after overflow", v, 32);
        rd(A_RAW, v);   chk("R6 tx overflow latched", (v >> 1) & 1, 1);
        for (int i = 1; i < 5; i++) begin
            take(v); chk("R2 tx order first batch", v, 16'h1000 + i);
        end
        for (int i = 0; i < 28; i++) begin
            take(v); chk("R6 tx order after drop", v, 16'h2000 + i);
        end
        chk("R2 tx avail low", eng_tx_avail, 0);

        // R4 receive strict threshold, R2 order, R7 underflow
        rx_in(16'hA0); rx_in(16'hA1);
        rd(A_RAW, v);   chk("R4 rx at thr no irq", (v >> 4) & 1, 0);
        rx_in(16'hA2);
        rd(A_RAW, v);   chk("R4 rx above thr", (v >> 4) & 1, 1);
        for (int i = 0; i < 3; i++) begin
            rd(A_RXD, v); chk("R2 rx order", v, 16'hA0 + i);
        end
        rd(A_RXD, v);   chk("R7 empty read zero", v, 0);
        rd(A_RXLVL, v); chk("R7 level stays 0", v, 0);
        rd(A_RAW, v);   chk("R7 underflow latched", (v >> 2) & 1, 1);

        // R6 receive overflow
        for (int i = 0; i < 33; i++) rx_in(DW'(16'hB000 + i));
        rd(A_RXLVL, v); chk("R6 rx level full", v, 32);
        rd(A_RAW, v);   chk("R6 rx overflow latched", (v >> 3) & 1, 1);
        rd(A_STAT, v);  chk("R3 rx full status", v, status_exp(0, 32, 1));

        // R5 mask
        wr(A_MASK, 5'h08);
        chk("R5 irq on masked bit", irq, 1);
        rd(A_MSKD, v);  chk("R5 masked vector", v, 8);
        wr(A_MASK, 0);
        chk("R5 irq off", irq, 0);

        // R8 individual and global clear
        wr(A_CLR, 4);
        rd(A_RAW, v);   chk("R8 clear rx ovf only", (v >> 1) & 7, 3'b011);
        wr(A_CLR, 2);
        rd(A_RAW, v);   chk("R8 clear rx und only", (v >> 1) & 7, 3'b001);
        wr(A_TXD, 16'h0); // not full: no event
        for (int i = 0; i < 40; i++) wr(A_TXD, 16'h1);
        rx_in(16'h1);
        wr(A_CLR, 1);
        rd(A_RAW, v);   chk("R8 clear all", (v >> 1) & 7, 0);
        for (int i = 0; i < 32; i++) take(v);

        // R11 DMA requests
        chk("R11 tx req off", tx_dma_req, 0);
        chk("R11 rx req off", rx_dma_req, 0);
        wr(A_TXDLVL, 3); wr(A_RXDLVL, 31);
        wr(A_DMAEN, 2);
        chk("R11 tx req on", tx_dma_req, 1);
        chk("R11 rx req disabled", rx_dma_req, 0);
        wr(A_DMAEN, 3);
        chk("R11 rx req above level", rx_dma_req, 1);
        rd(A_RXD, v);
        chk("R11 rx req at level", rx_dma_req, 0);
        for (int i = 0; i < 4; i++) wr(A_TXD, 16'h7);
        chk("R11 tx req above level", tx_dma_req, 0);

        // R9 flush on disable
        @(negedge clk); en = 1'b0;
        @(posedge clk); #1;
        rd(A_TXLVL, v); chk("R9 tx flushed", v, 0);
        rd(A_RXLVL, v); chk("R9 rx flushed", v, 0);
        @(negedge clk); en = 1'b1;
        wr(A_CLR, 1);

        // R2 randomized stream against queue models
        for (int it = 0; it < 600; it++) begin
            logic [DW-1:0] d;
            d = DW'($urandom);
            case ($urandom % 4)
                0: begin
                    wr(A_TXD, d);
                    if (tq.size() < DEPTH) tq.push_back(d);
                end
                1: begin
                    chk("R2 rand tx avail", eng_tx_avail, tq.size() != 0);
                    take(v);
                    if (tq.size() != 0) chk("R2 rand tx data", v, tq.pop_front());
                end
                2: begin
                    rx_in(d);
                    if (rq.size() < DEPTH) rq.push_back(d);
                end
                default: begin
                    rd(A_RXD, v);
                    chk("R2 rand rx data", v, (rq.size() != 0) ? rq.pop_front() : '0);
                end
            endcase
            if (it % 8 == 0) begin
                rd(A_TXLVL, v); chk("R2 rand tx level", v, tq.size());
                rd(A_RXLVL, v); chk("R2 rand rx level", v, rq.size());
            end
        end

        finish_sim();
    end

endmodule